// File: doc/BRIEF.md
# Channelised Command Submission FIFO

This block sits behind a programmed-I/O write window that is divided by channel and subchannel. Each bus write is split into a channel number, a subchannel number and a method offset. The write is tagged as usable or unusable and then queued for a downstream command engine.

Entries can come from two sources. Bus writes land in a multi-entry main queue. Commands injected by an internal software path land in a one-entry side cache, and that cache is always served first. The read side presents one entry at a time. A usable entry goes out on the processing port. An unusable entry goes out on the runout port, so it is neither dropped nor allowed to stall the queue.

Only one channel is active at a time, and it is channel 0 after reset. A context-switch request selects a new active channel. It is held off until both caches are empty, and new entries are refused while it waits.

Top module: `cmdq_top`

## Requirements
- R1: After reset the active channel is 0, `ctx_busy` is low, `bus_ready` and `inj_ready` are high, and neither `proc_valid` nor `ro_valid` is asserted.
- R2: A write to address A is presented with channel A[18:16], subchannel A[15:13], method offset A[12:0] and its data unchanged.
- R3: Entries from the main queue leave in the order they were accepted.
- R4: An entry whose channel is not the active channel at acceptance is presented on the runout port (`ro_valid`) and never on the processing port.
- R5: An entry whose address has A[1:0] not equal to 0 is presented on the runout port.
- R6: The injection cache holds one entry. `inj_ready` is low while it is occupied, and an injection offered then is not stored.
- R7: While the injection cache is occupied, its entry is presented ahead of any entry waiting in the main queue.
- R8: With FIFO_DEPTH entries queued, `bus_ready` is low and a write offered then is not stored.
- R9: A context-switch request raises `ctx_busy` and lowers `bus_ready` and `inj_ready`. `active_chan` takes the requested value only on the clock edge after both caches are empty. A request made while one is already pending is ignored.
- R10: A presented entry is removed only by the ready signal of the port it is presented on. The ready signal of the other port leaves it in place.
- R11: `proc_valid` and `ro_valid` are never high together, and an injected entry being presented stays unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus write offered |
| bus_addr | input | 19 | Byte address within the channel window |
| bus_data | input | 32 | Write data |
| bus_ready | output | 1 | Bus write accepted this cycle when high |
| inj_valid | input | 1 | Internal injection offered |
| inj_addr | input | 19 | Injection address, decoded like a bus address |
| inj_data | input | 32 | Injection data |
| inj_ready | output | 1 | Injection cache can take an entry |
| ctx_req | input | 1 | Context-switch request strobe |
| ctx_chan | input | 3 | Requested channel |
| active_chan | output | 3 | Currently active channel |
| ctx_busy | output | 1 | A context switch is waiting for the caches to drain |
| out_chan | output | 3 | Presented entry channel |
| out_subch | output | 3 | Presented entry subchannel |
| out_method | output | 13 | Presented entry method offset |
| out_data | output | 32 | Presented entry data |
| proc_valid | output | 1 | Presented entry is usable |
| proc_ready | input | 1 | Processing side takes the entry |
| ro_valid | output | 1 | Presented entry is diverted to runout |
| ro_ready | input | 1 | Runout side takes the entry |

## Verification
The assertions assume that the bus and injection sources honour their ready signals. That means a write counts as accepted only in a cycle where ready is high, and the sinks raise a ready signal only when they mean to take an entry. The bench changes inputs only on falling edges. It holds each valid for exactly one cycle and raises one sink ready at a time, so every acceptance falls on a known rising edge. Context-switch requests are issued as single-cycle strobes.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 32;
  localparam int CHAN_W = 3;
  localparam int SUB_W  = 3;
  localparam int MTH_W  = 13;

  typedef struct packed {
    logic              ok;
    logic [CHAN_W-1:0] chan;
    logic [SUB_W-1:0]  subch;
    logic [MTH_W-1:0]  mth;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic logic word_aligned(input logic [ADDR_W-1:0] a);
    return a[1:0] == 2'b00;
  endfunction

  function automatic cmd_t cmd_decode(input logic [ADDR_W-1:0] a,
                                      input logic [DATA_W-1:0] d,
                                      input logic [CHAN_W-1:0] active);
    cmd_t c;
    c.chan  = a[MTH_W+SUB_W+CHAN_W-1:MTH_W+SUB_W];
    c.subch = a[MTH_W+SUB_W-1:MTH_W];
    c.mth   = a[MTH_W-1:0];
    c.data  = d;
    c.ok    = (c.chan == active) && word_aligned(a);
    return c;
  endfunction
endpackage

// File: rtl/cmdq_pusher.sv
module cmdq_pusher
  import cmdq_pkg::*;
(
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              bus_ready,
  input  logic [CHAN_W-1:0] active_chan,
  input  logic              hold,
  input  logic              fifo_full,
  output logic              push,
  output cmd_t              push_entry
);
  always_comb begin
    bus_ready  = !fifo_full && !hold;
    push       = bus_valid && bus_ready;
    push_entry = cmd_decode(bus_addr, bus_data, active_chan);
  end
endmodule

// File: rtl/cmdq_inject.sv
module cmdq_inject
  import cmdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [CHAN_W-1:0] active_chan,
  input  logic              hold,
  input  logic              pop,
  output logic              full,
  output cmd_t              entry
);
  logic take;
  assign in_ready = !full && !hold;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= 1'b0;
      entry <= '0;
    end else if (take) begin
      full  <= 1'b1;
      entry <= cmd_decode(in_addr, in_data, active_chan);
    end else if (pop) begin
      full  <= 1'b0;
    end
  end

  a_r6_pop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> full);
  a_r6_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full && $stable(entry));
endmodule

// File: rtl/cmdq_fifo.sv
module cmdq_fifo
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  cmd_t push_entry,
  input  logic pop,
  output cmd_t head,
  output logic empty,
  output logic full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  cmd_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r3_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r3_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !push && !pop |=> $stable(count));
endmodule

// File: rtl/cmdq_puller.sv
module cmdq_puller
  import cmdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inj_full,
  input  cmd_t              inj_entry,
  input  logic              fifo_empty,
  input  cmd_t              fifo_head,
  output logic              inj_pop,
  output logic              fifo_pop,
  output logic [CHAN_W-1:0] out_chan,
  output logic [SUB_W-1:0]  out_subch,
  output logic [MTH_W-1:0]  out_method,
  output logic [DATA_W-1:0] out_data,
  output logic              proc_valid,
  input  logic              proc_ready,
  output logic              ro_valid,
  input  logic              ro_ready
);
  cmd_t sel;
  logic any, take;

  always_comb begin
    sel        = inj_full ? inj_entry : fifo_head;
    any        = inj_full || !fifo_empty;
    proc_valid = any && sel.ok;
    ro_valid   = any && !sel.ok;
    take       = (proc_valid && proc_ready) || (ro_valid && ro_ready);
    inj_pop    = take && inj_full;
    fifo_pop   = take && !inj_full;
    out_chan   = sel.chan;
    out_subch  = sel.subch;
    out_method = sel.mth;
    out_data   = sel.data;
  end

  a_r7_inject_first: assert property (@(posedge clk) disable iff (!rst_n)
    inj_full |-> !fifo_pop);
  a_r11_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(proc_valid && ro_valid));
  a_r11_inj_hold: assert property (@(posedge clk) disable iff (!rst_n)
    inj_full && !inj_pop |=> inj_full && $stable(out_data) && $stable(out_method));
  a_r10_own_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_pop || fifo_pop) |-> ((proc_valid && proc_ready) || (ro_valid && ro_ready)));
endmodule

// File: rtl/cmdq_top.sv
module cmdq_top
  import cmdq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              bus_ready,
  input  logic              inj_valid,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [DATA_W-1:0] inj_data,
  output logic              inj_ready,
  input  logic              ctx_req,
  input  logic [CHAN_W-1:0] ctx_chan,
  output logic [CHAN_W-1:0] active_chan,
  output logic              ctx_busy,
  output logic [CHAN_W-1:0] out_chan,
  output logic [SUB_W-1:0]  out_subch,
  output logic [MTH_W-1:0]  out_method,
  output logic [DATA_W-1:0] out_data,
  output logic              proc_valid,
  input  logic              proc_ready,
  output logic              ro_valid,
  input  logic              ro_ready
);
  logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
  cmd_t              fifo_in, fifo_head;
  logic              inj_full, inj_pop;
  cmd_t              inj_entry;
  logic              drained;
  logic [CHAN_W-1:0] ctx_target;

  assign drained = fifo_empty && !inj_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_chan <= '0;
      ctx_busy    <= 1'b0;
      ctx_target  <= '0;
    end else if (ctx_busy) begin
      if (drained) begin
        active_chan <= ctx_target;
        ctx_busy    <= 1'b0;
      end
    end else if (ctx_req) begin
      ctx_busy   <= 1'b1;
      ctx_target <= ctx_chan;
    end
  end

  cmdq_pusher u_push (
    .bus_valid  (bus_valid),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data),
    .bus_ready  (bus_ready),
    .active_chan(active_chan),
    .hold       (ctx_busy),
    .fifo_full  (fifo_full),
    .push       (fifo_push),
    .push_entry (fifo_in)
  );

  cmdq_inject u_inj (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (inj_valid),
    .in_addr    (inj_addr),
    .in_data    (inj_data),
    .in_ready   (inj_ready),
    .active_chan(active_chan),
    .hold       (ctx_busy),
    .pop        (inj_pop),
    .full       (inj_full),
    .entry      (inj_entry)
  );

  cmdq_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fifo_push),
    .push_entry(fifo_in),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  cmdq_puller u_pull (
    .clk       (clk),
    .rst_n     (rst_n),
    .inj_full  (inj_full),
    .inj_entry (inj_entry),
    .fifo_empty(fifo_empty),
    .fifo_head (fifo_head),
    .inj_pop   (inj_pop),
    .fifo_pop  (fifo_pop),
    .out_chan  (out_chan),
    .out_subch (out_subch),
    .out_method(out_method),
    .out_data  (out_data),
    .proc_valid(proc_valid),
    .proc_ready(proc_ready),
    .ro_valid  (ro_valid),
    .ro_ready  (ro_ready)
  );

  a_r9_switch_drained: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_chan) |-> $past(drained));
  a_r9_hold_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_busy |-> !bus_ready && !inj_ready);
  a_r9_busy_until_switch: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_busy && !drained |=> ctx_busy && $stable(active_chan));
endmodule

// File: tb/sim_cmdq_top.sv
module sim_cmdq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [18:0] bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic        bus_ready;
  logic        inj_valid = 1'b0;
  logic [18:0] inj_addr = '0;
  logic [31:0] inj_data = '0;
  logic        inj_ready;
  logic        ctx_req = 1'b0;
  logic [2:0]  ctx_chan = '0;
  logic [2:0]  active_chan;
  logic        ctx_busy;
  logic [2:0]  out_chan;
  logic [2:0]  out_subch;
  logic [12:0] out_method;
  logic [31:0] out_data;
  logic        proc_valid;
  logic        proc_ready = 1'b0;
  logic        ro_valid;
  logic        ro_ready = 1'b0;

  int applied = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  cmdq_top u0 (.*);

  localparam int NV = 8;
  localparam logic [18:0] V_ADDR [NV] = '{19'h00000, 19'h02004, 19'h0FFFC, 19'h34010,
                                          19'h06002, 19'h7E000, 19'h0A100, 19'h0C008};
  localparam logic [31:0] V_DATA [NV] = '{32'h11111111, 32'hA5A5A5A5, 32'hFFFFFFFF, 32'h00C0FFEE,
                                          32'h12345678, 32'h0BADF00D, 32'h00000000, 32'h80000001};

  function automatic bit usable(input logic [18:0] a, input logic [2:0] act);
    return (a / 19'h10000) % 8 == act && a % 4 == 0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [18:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic inj_write(input logic [18:0] a, input logic [31:0] d);
    inj_valid = 1'b1; inj_addr = a; inj_data = d;
    @(negedge clk);
    inj_valid = 1'b0;
  endtask

  task automatic take(input string req, input bit to_proc, input logic [18:0] a, input logic [31:0] d);
    chk(req, {63'd0, proc_valid}, {63'd0, to_proc});
    chk(req, {63'd0, ro_valid}, {63'd0, !to_proc});
    chk(req, {42'd0, out_chan, out_subch, out_method},
        {42'd0, (a / 19'h10000) % 8, 3'((a / 19'h2000) % 8), 13'(a % 19'h2000)});
    chk(req, {32'd0, out_data}, {32'd0, d});
    if (to_proc) proc_ready = 1'b1; else ro_ready = 1'b1;
    @(negedge clk);
    proc_ready = 1'b0; ro_ready = 1'b0;
  endtask

  task automatic ctx_switch(input logic [2:0] c);
    ctx_req = 1'b1; ctx_chan = c;
    @(negedge clk);
    ctx_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 active", {61'd0, active_chan}, 64'd0);
    chk("R1 busy", {63'd0, ctx_busy}, 64'd0);
    chk("R1 ready", {62'd0, bus_ready, inj_ready}, 64'd3);
    chk("R1 outputs", {62'd0, proc_valid, ro_valid}, 64'd0);

    // R2 decode, R4 inactive channel, R5 misaligned: vector table
    for (int i = 0; i < NV; i++) begin
      bus_write(V_ADDR[i], V_DATA[i]);
      take(usable(V_ADDR[i], 3'd0) ? "R2 decode to proc" : "R4/R5 runout",
           usable(V_ADDR[i], 3'd0), V_ADDR[i], V_DATA[i]);
    end

    // R3 ordering and R8 full
    for (int i = 0; i < 32; i++)
      bus_write(19'((i % 8) * 19'h2000 + i * 4), 32'd100 + i);
    chk("R8 ready low when full", {63'd0, bus_ready}, 64'd0);
    bus_write(19'h00040, 32'hDEADBEEF);
    for (int i = 0; i < 32; i++)
      take("R3 order", 1'b1, 19'((i % 8) * 19'h2000 + i * 4), 32'd100 + i);
    chk("R8 extra write dropped", {62'd0, proc_valid, ro_valid}, 64'd0);

    // R6 single injection slot, R7 priority
    bus_write(19'h00010, 32'hA1);
    bus_write(19'h00014, 32'hA2);
    inj_write(19'h04020, 32'hB1);
    chk("R6 inj_ready low", {63'd0, inj_ready}, 64'd0);
    inj_write(19'h04024, 32'hB2);
    take("R7 inject first", 1'b1, 19'h04020, 32'hB1);
    take("R7 then main", 1'b1, 19'h00010, 32'hA1);
    take("R3 main order", 1'b1, 19'h00014, 32'hA2);
    chk("R6 second inject dropped", {62'd0, proc_valid, ro_valid}, 64'd0);
    inj_write(19'h3C000, 32'hB3);
    take("R4 injected inactive", 1'b0, 19'h3C000, 32'hB3);

    // R9 context switch waits for drain
    bus_write(19'h00100, 32'hC1);
    ctx_switch(3'd5);
    chk("R9 busy", {63'd0, ctx_busy}, 64'd1);
    chk("R9 inputs held", {62'd0, bus_ready, inj_ready}, 64'd0);
    bus_write(19'h50000, 32'hC2);
    ctx_switch(3'd6);
    repeat (2) @(negedge clk);
    chk("R9 not yet switched", {61'd0, active_chan}, 64'd0);
    take("R9 pending entry", 1'b1, 19'h00100, 32'hC1);
    chk("R9 held during drain", {62'd0, proc_valid, ro_valid}, 64'd0);
    @(negedge clk);
    chk("R9 switched", {61'd0, active_chan}, 64'd5);
    chk("R9 busy cleared", {63'd0, ctx_busy}, 64'd0);
    chk("R9 ready back", {63'd0, bus_ready}, 64'd1);
    bus_write(19'h52008, 32'hD1);
    take("R9 new channel usable", 1'b1, 19'h52008, 32'hD1);

    // R10 wrong ready does not remove, R4 old channel now inactive
    bus_write(19'h02008, 32'hE1);
    proc_ready = 1'b1;
    @(negedge clk);
    proc_ready = 1'b0;
    chk("R10 held on wrong ready", {63'd0, ro_valid}, 64'd1);
    take("R4 old channel runout", 1'b0, 19'h02008, 32'hE1);
    chk("R10 drained", {62'd0, proc_valid, ro_valid}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule